// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source state for a bank of interrupt inputs and decides when each source is handed to a downstream presenter. Each source is fixed at build time as either message-style, where a trigger is a one-cycle event, or level-style, where the source follows a wire. Every source holds a target server, a priority and a small set of status bits: masked-pending, rejected, asserted and sent. These bits decide when an event that was held back is replayed.

The presenter sits on the other side of a request port that carries a server, a global source number and a priority. It answers with reject and end-of-interrupt commands, which carry global numbers, and it can issue a resend broadcast. Configuration writes set a source's server and priority by local index. A priority of all ones masks the source. Global numbers are the local index plus a base offset. Commands whose number falls outside the bank are dropped.

When several sources become ready in the same cycle, they are queued and issued one per cycle in ascending index order.

Top module: `ist_source_ctrl`

## Requirements
- R1: After reset every source has priority 0xFF (masked), server 0 and all status bits clear, and `req_valid` is low. Triggering any source before it is configured presents nothing.
- R2: A message source whose `src_in` bit is high in a cycle is presented if its priority is not 0xFF. Otherwise its masked-pending bit is set and nothing is presented. No request ever carries priority 0xFF.
- R3: A configuration write to local index `cfg_idx` sets that source's server and priority. If a message source has masked-pending set and the new priority is not 0xFF, the bit is cleared and the source is presented exactly once. A write to a message source with no pending state presents nothing.
- R4: A level source follows `src_in`. When its input changes, when it is configured, or on resend, it is presented if it is asserted, unmasked and not already sent, and its sent bit is then set. While sent, it is not presented again.
- R5: A reject for a message source sets its rejected bit. On resend, that bit is cleared and the source is presented once if unmasked; if masked, the event is dropped. A reject for a level source clears its sent bit, and the next resend re-evaluates it.
- R6: An end-of-interrupt clears a level source's sent bit without presenting it by itself. For a message source it has no effect, so a later resend presents nothing.
- R7: The request number is the base offset (default 0x1000) plus the local index. Reject and end-of-interrupt numbers outside base to base+N-1 are ignored, including numbers whose low bits alias a valid index.
- R8: Sources that become eligible in the same cycle are presented one per cycle in ascending index order. A source made eligible by inputs sampled at clock edge k appears on the request port after edge k+1.
- R9: A configuration write of priority 0xFF to a source that is queued but not yet issued withdraws it. A message source keeps it as masked-pending; a level source clears its sent bit. A later unmasking write then presents it.
- R10: Source kinds come from the parameter `LEVEL_MASK` (bit i set means level-style). For a message source, each cycle with `src_in` high is a separate trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Per-source input: trigger for message sources, level for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source written |
| cfg_server | input | SRV_W | Server written |
| cfg_prio | input | 8 | Priority written (0xFF masks) |
| rej_valid | input | 1 | Reject command strobe |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend broadcast strobe |
| req_valid | output | 1 | Presentation request valid |
| req_server | output | SRV_W | Target server of the request |
| req_num | output | NUM_W | Global source number of the request |
| req_prio | output | 8 | Priority of the request |

## Verification
Each message source is swept across several priorities. Each sweep checks that the global number, server and priority match arithmetic expectations, so a mismatch shows up as a wrong field rather than a missing request. A simultaneous trigger of all message sources checks the ascending order and the exact two-edge latency. Holding one message input high for several cycles separates the edge semantics from the level semantics.

Level sources are driven through raise, hold, end-of-interrupt, reject and resend sequences, which show that only the sent bit gates re-presentation. Command numbers that alias a valid index in their low bits show that range checking uses the full number. Masking a source while it is queued behind a lower-index one checks withdrawal, as opposed to issue of a stale request.

// File: rtl/ist_pkg.sv
package ist_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_OFF = '1;
endpackage

// File: rtl/ist_src_cell.sv
// State and replay rules for one interrupt source.
module ist_src_cell
  import ist_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0,
  parameter int SRV_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_server,
  input  prio_t            cfg_prio,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             resend,
  input  logic             grant,
  output logic             queued,
  output prio_t            prio,
  output logic [SRV_W-1:0] server
);
  logic  mpend_q, rej_q, asrt_q, sent_q, queued_q;
  logic  mp_n, rj_n, as_n, st_n, q_n;
  prio_t prio_q, prio_eff;
  logic [SRV_W-1:0] srv_q;
  logic  masked;

  assign prio_eff = cfg_hit ? cfg_prio : prio_q;
  assign masked   = (prio_eff == PRIO_OFF);

  always_comb begin
    mp_n = mpend_q;
    rj_n = rej_q;
    as_n = asrt_q;
    st_n = sent_q;
    q_n  = queued_q & ~grant;
    if (IS_LEVEL) begin
      as_n = src;
      if (rej_hit || eoi_hit) st_n = 1'b0;
      if (cfg_hit && masked && q_n) begin
        q_n  = 1'b0;
        st_n = 1'b0;
      end
      if ((as_n != asrt_q || cfg_hit || resend) && as_n && !masked && !st_n) begin
        q_n  = 1'b1;
        st_n = 1'b1;
      end
    end else begin
      if (rej_hit) rj_n = 1'b1;
      if (resend && rj_n) begin
        rj_n = 1'b0;
        if (!masked) q_n = 1'b1;
      end
      if (src) begin
        if (masked) mp_n = 1'b1;
        else        q_n  = 1'b1;
      end
      if (cfg_hit) begin
        if (masked && q_n) begin
          q_n  = 1'b0;
          mp_n = 1'b1;
        end else if (!masked && mp_n) begin
          mp_n = 1'b0;
          q_n  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mpend_q  <= 1'b0;
      rej_q    <= 1'b0;
      asrt_q   <= 1'b0;
      sent_q   <= 1'b0;
      queued_q <= 1'b0;
      prio_q   <= PRIO_OFF;
      srv_q    <= '0;
    end else begin
      mpend_q  <= mp_n;
      rej_q    <= rj_n;
      asrt_q   <= as_n;
      sent_q   <= st_n;
      queued_q <= q_n;
      prio_q   <= prio_eff;
      if (cfg_hit) srv_q <= cfg_server;
    end
  end

  assign queued = queued_q;
  assign prio   = prio_q;
  assign server = srv_q;
endmodule

// File: rtl/ist_pick_low.sv
// Fixed-priority pick of the lowest set request bit.
module ist_pick_low #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ist_source_ctrl.sv
module ist_source_ctrl
  import ist_pkg::*;
#(
  parameter int             NSRC       = 8,
  parameter int             SRV_W      = 4,
  parameter int             NUM_W      = 16,
  parameter int             BASE       = 'h1000,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int            IDX_W      = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_in,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic [7:0]       cfg_prio,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             req_valid,
  output logic [SRV_W-1:0] req_server,
  output logic [NUM_W-1:0] req_num,
  output logic [7:0]       req_prio
);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] LAST_N = NUM_W'(BASE + NSRC - 1);

  logic             rej_ok, eoi_ok, cfg_ok;
  logic [NUM_W-1:0] rej_off, eoi_off;
  logic [IDX_W-1:0] rej_idx, eoi_idx, pick_idx;
  logic [NSRC-1:0]  queued, grant;
  prio_t            prio_a [NSRC];
  logic [SRV_W-1:0] srv_a  [NSRC];

  assign rej_ok  = rej_valid && (rej_num >= BASE_N) && (rej_num <= LAST_N);
  assign eoi_ok  = eoi_valid && (eoi_num >= BASE_N) && (eoi_num <= LAST_N);
  assign rej_off = rej_num - BASE_N;
  assign eoi_off = eoi_num - BASE_N;
  assign rej_idx = rej_off[IDX_W-1:0];
  assign eoi_idx = eoi_off[IDX_W-1:0];
  assign cfg_ok  = cfg_we && (32'(cfg_idx) < NSRC);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ist_src_cell #(
      .IS_LEVEL (LEVEL_MASK[g]),
      .SRV_W    (SRV_W)
    ) u_cell (
      .clk        (clk),
      .rst        (rst),
      .src        (src_in[g]),
      .cfg_hit    (cfg_ok && cfg_idx == IDX_W'(g)),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .rej_hit    (rej_ok && rej_idx == IDX_W'(g)),
      .eoi_hit    (eoi_ok && eoi_idx == IDX_W'(g)),
      .resend     (resend),
      .grant      (grant[g]),
      .queued     (queued[g]),
      .prio       (prio_a[g]),
      .server     (srv_a[g])
    );
  end

  ist_pick_low #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .req (queued),
    .gnt (grant),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_server <= '0;
      req_num    <= '0;
      req_prio   <= PRIO_OFF;
    end else begin
      req_valid  <= |queued;
      req_server <= srv_a[pick_idx];
      req_num    <= BASE_N + NUM_W'(pick_idx);
      req_prio   <= prio_a[pick_idx];
    end
  end
endmodule

// File: rtl/ist_source_ctrl_chk.sv
module ist_source_ctrl_chk #(
  parameter int              NSRC       = 8,
  parameter int              NUM_W      = 16,
  parameter int              BASE       = 'h1000,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int             IDX_W      = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst,
  input logic             rej_valid,
  input logic [NUM_W-1:0] rej_num,
  input logic             eoi_valid,
  input logic [NUM_W-1:0] eoi_num,
  input logic             req_valid,
  input logic [NUM_W-1:0] req_num,
  input logic [7:0]       req_prio
);
  localparam logic [NUM_W-1:0] BASE_N = NUM_W'(BASE);
  localparam logic [NUM_W-1:0] LAST_N = NUM_W'(BASE + NSRC - 1);

  logic             rst_d;
  logic [NSRC-1:0]  outst;
  logic [NUM_W-1:0] req_off, rej_off, eoi_off;
  logic [IDX_W-1:0] req_idx;

  assign req_off = req_num - BASE_N;
  assign rej_off = rej_num - BASE_N;
  assign eoi_off = eoi_num - BASE_N;
  assign req_idx = req_off[IDX_W-1:0];

  always_ff @(posedge clk) rst_d <= rst;

  // Level sources presented and not yet rejected or completed
  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (req_valid && req_idx == IDX_W'(i) && LEVEL_MASK[i]) outst[i] <= 1'b1;
        if (rej_valid && rej_num >= BASE_N && rej_num <= LAST_N && rej_off == NUM_W'(i))
          outst[i] <= 1'b0;
        if (eoi_valid && eoi_num >= BASE_N && eoi_num <= LAST_N && eoi_off == NUM_W'(i))
          outst[i] <= 1'b0;
      end
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !req_valid); // R1
  AST_NO_MASKED_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_prio != 8'hFF); // R2
  AST_NUM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_num >= BASE_N && req_num <= LAST_N)); // R7
  AST_LEVEL_ONCE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && LEVEL_MASK[req_idx]) |-> !outst[req_idx]); // R4
endmodule

bind ist_source_ctrl ist_source_ctrl_chk #(
  .NSRC(NSRC), .NUM_W(NUM_W), .BASE(BASE), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
  .clk(clk), .rst(rst), .rej_valid(rej_valid), .rej_num(rej_num),
  .eoi_valid(eoi_valid), .eoi_num(eoi_num), .req_valid(req_valid),
  .req_num(req_num), .req_prio(req_prio)
);

// File: tb/test_ist_source_ctrl.sv
module test_ist_source_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 'h1000;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  src_in;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [3:0]  cfg_server;
  logic [7:0]  cfg_prio;
  logic        rej_valid, eoi_valid, resend;
  logic [15:0] rej_num, eoi_num;
  logic        req_valid;
  logic [3:0]  req_server;
  logic [15:0] req_num;
  logic [7:0]  req_prio;

  int n_chk = 0;
  int n_fail = 0;
  int cap_cnt = 0;
  logic [15:0] cap_num  [64];
  logic [7:0]  cap_prio [64];
  logic [3:0]  cap_srv  [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  ist_source_ctrl i_ist_source_ctrl (
    .clk(clk), .rst(rst), .src_in(src_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .rej_valid(rej_valid),
    .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend(resend), .req_valid(req_valid), .req_server(req_server),
    .req_num(req_num), .req_prio(req_prio)
  );

  always @(negedge clk) begin
    if (!rst && req_valid && cap_cnt < 64) begin
      cap_num[cap_cnt]  = req_num;
      cap_prio[cap_cnt] = req_prio;
      cap_srv[cap_cnt]  = req_server;
      cap_cnt = cap_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    cap_cnt = 0;
  endtask

  task automatic cfg(input int i, input int s, input int p);
    cfg_we = 1'b1; cfg_idx = 3'(i); cfg_server = 4'(s); cfg_prio = 8'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    src_in = src_in | m;
    @(negedge clk);
    src_in = src_in & ~m;
  endtask

  task automatic rej(input int n);
    rej_valid = 1'b1; rej_num = 16'(n);
    @(negedge clk);
    rej_valid = 1'b0;
  endtask

  task automatic eoi(input int n);
    eoi_valid = 1'b1; eoi_num = 16'(n);
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic rsnd();
    resend = 1'b1;
    @(negedge clk);
    resend = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    idle(6);
    chk(cap_cnt == 0, tag, cap_cnt, 0);
    clr();
  endtask

  task automatic expect_one(input string tag, input int num, input int p, input int s);
    idle(6);
    chk(cap_cnt == 1, tag, cap_cnt, 1);
    chk(cap_num[0] == 16'(num), tag, int'(cap_num[0]), num);
    chk(cap_prio[0] == 8'(p), tag, int'(cap_prio[0]), p);
    chk(cap_srv[0] == 4'(s), tag, int'(cap_srv[0]), s);
    clr();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    report();
  end

  initial begin
    rst = 1'b1; src_in = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_server = '0;
    cfg_prio = '0; rej_valid = 1'b0; rej_num = '0; eoi_valid = 1'b0;
    eoi_num = '0; resend = 1'b0;
    idle(3);
    chk(req_valid == 1'b0, "R1 in reset", int'(req_valid), 0);
    rst = 1'b0;
    idle(2);
    chk(req_valid == 1'b0, "R1 after reset", int'(req_valid), 0);
    clr();

    // R1 R2: triggers on masked sources present nothing
    pulse(8'h0F);
    expect_none("R1 R2 masked trigger");

    // R3: unmasking replays masked-pending once per source
    cfg(2, 3, 5);   expect_one("R3 replay src2", BASE + 2, 5, 3);
    cfg(0, 1, 8);   expect_one("R3 replay src0", BASE + 0, 8, 1);
    cfg(1, 9, 'h40); expect_one("R3 replay src1", BASE + 1, 'h40, 9);
    cfg(3, 14, 'hFE); expect_one("R3 replay src3", BASE + 3, 'hFE, 14);
    cfg(2, 3, 6);   expect_none("R3 no pending");

    // R2 R7: sweep message sources and priorities
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        int p;
        int s;
        p = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 'h7F : 'hFE;
        s = (i * 5 + p) % 16;
        cfg(i, s, p);
        clr();
        pulse(8'(1 << i));
        expect_one("R2 R7 sweep", BASE + i, p, s);
      end
    end

    // R8: simultaneous triggers, latency and ascending order
    clr();
    src_in = 8'h0F;
    @(negedge clk);
    chk(req_valid == 1'b0, "R8 latency edge1", int'(req_valid), 0);
    src_in = '0;
    @(negedge clk);
    chk(req_valid == 1'b1, "R8 latency edge2", int'(req_valid), 1);
    idle(6);
    chk(cap_cnt == 4, "R8 count", cap_cnt, 4);
    for (int k = 0; k < 4; k++)
      chk(cap_num[k] == 16'(BASE + k), "R8 order", int'(cap_num[k]), BASE + k);
    clr();

    // R10: message input held high three cycles gives three triggers
    src_in[0] = 1'b1;
    idle(3);
    src_in[0] = 1'b0;
    idle(6);
    chk(cap_cnt == 3, "R10 held message", cap_cnt, 3);
    clr();

    // R9: mask a queued message source behind lower indices
    src_in = 8'h0F;
    @(negedge clk);
    src_in = '0;
    cfg(3, 2, 'hFF);
    idle(6);
    chk(cap_cnt == 3, "R9 withdraw msg count", cap_cnt, 3);
    chk(cap_num[2] == 16'(BASE + 2), "R9 withdraw msg last", int'(cap_num[2]), BASE + 2);
    clr();
    cfg(3, 2, 'h40); expect_one("R9 msg unmask", BASE + 3, 'h40, 2);

    // R5 R6: message reject, resend, eoi
    rej(BASE + 1); expect_none("R5 reject silent");
    rsnd();        expect_one("R5 resend msg", BASE + 1, 'hFE, (5 + 'hFE) % 16);
    rsnd();        expect_none("R5 resend once");
    eoi(BASE + 1); rsnd(); expect_none("R6 eoi msg no effect");
    rej(BASE + 2); cfg(2, 4, 'hFF); rsnd(); expect_none("R5 resend masked");
    cfg(2, 4, 9);  expect_none("R5 masked resend dropped");

    // R4 R5 R6: level source
    cfg(5, 2, 'h10); expect_none("R4 cfg low level");
    src_in[5] = 1'b1; expect_one("R4 level raise", BASE + 5, 'h10, 2);
    rsnd();        expect_none("R4 sent blocks");
    cfg(5, 2, 'h11); expect_none("R4 cfg while sent");
    eoi(BASE + 5); expect_none("R6 eoi alone");
    rsnd();        expect_one("R6 eoi then resend", BASE + 5, 'h11, 2);
    rej(BASE + 5); expect_none("R5 level reject silent");
    rsnd();        expect_one("R5 level resend", BASE + 5, 'h11, 2);

    // R7: out-of-range numbers aliasing index 5 are ignored
    eoi(BASE + 13); rsnd(); expect_none("R7 eoi above window");
    rej(BASE - 3);  rsnd(); expect_none("R7 reject below window");
    src_in[5] = 1'b0;
    eoi(BASE + 5); rsnd(); expect_none("R4 deasserted");

    // R4: level high while masked, then unmasked
    src_in[6] = 1'b1; expect_none("R4 masked level");
    cfg(6, 7, 'h22);  expect_one("R4 unmask level", BASE + 6, 'h22, 7);

    // R9: level withdrawn behind message source 0
    cfg(7, 1, 'h30);
    clr();
    src_in[0] = 1'b1; src_in[7] = 1'b1;
    @(negedge clk);
    src_in[0] = 1'b0;
    cfg(7, 1, 'hFF);
    idle(6);
    chk(cap_cnt == 1, "R9 level withdraw count", cap_cnt, 1);
    chk(cap_num[0] == 16'(BASE), "R9 level withdraw num", int'(cap_num[0]), BASE);
    clr();
    cfg(7, 1, 'h30); expect_one("R9 level unmask", BASE + 7, 'h30, 1);

    report();
  end
endmodule